// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller sits between a host that issues reads and writes with a flat word address and a dynamic RAM whose address pins are shared between a row phase and a column phase. The host offers one request at a time with a valid/ready handshake and gets back a single-cycle response pulse that carries read data. On the memory side the controller drives the shared address pins, the active-low row and column strobes, the active-low write enable and the write data. Read data comes back on a separate input.

The controller remembers which row was last opened and keeps the row strobe low after an access. A request that falls in that same row skips the row phase and finishes sooner. A request for a different row first closes the open row and precharges it, then runs a full access. A free-running timer spaces row refreshes so that every refresh slot in the retention window is used. Each refresh is a row-strobe-only cycle on the next row of a wrapping counter, and it leaves no row open.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: The host address is split with the row in bits [11:6] and the column in bits [5:0]. The row goes on `mem_addr` when `mem_ras_n` falls, and the column goes on `mem_addr` when `mem_cas_n` falls. `mem_cas_n` is low only while `mem_ras_n` is low.
- R2: When a request names the row that is still open, `mem_ras_n` does not fall again. `rsp_valid` is high in the 3rd cycle after the accepting clock edge, for exactly one cycle.
- R3: When no row is open, an access runs a row phase, a column setup, a column strobe and a completion. `rsp_valid` is high in the 4th cycle after acceptance.
- R4: When a request names a row other than the open one, `mem_ras_n` goes high for at least `T_PRE` cycles before it falls for the new row. `rsp_valid` is then due `T_PRE`+4 cycles after acceptance.
- R5: On a write, `mem_we_n` is low and `mem_dq_oe`/`mem_dq_out` carry the data for one full cycle before `mem_cas_n` falls, and they stay unchanged while it is low. A later read of the same address returns that data.
- R6: The controller starts a refresh every RETENTION_NS/(CLK_NS*REFRESH_COUNT) cycles. This is 156 cycles with a 10 ns clock, a 200000 ns window and 128 refreshes.
- R7: A refresh lowers `mem_ras_n` with the refresh row on `mem_addr` and never lowers `mem_cas_n`. Successive refreshes use consecutive rows, wrapping from 63 back to 0.
- R8: A refresh that is pending holds `req_ready` low until it has finished, so it goes ahead of new requests but never interrupts an accepted access. The first access after a refresh is a closed-row access (R3 timing).
- R9: While reset is active and right after it, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, faster than the memory cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address, row in the upper part |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid while `rsp_valid` is high |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | High while `mem_dq_out` is driven |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The acceptance edge is the clock edge at which `req_valid` and `req_ready` are both high. After that edge the bench counts falling edges until it sees `rsp_valid`, and compares the count with the requirement: 3 for a same-row hit, 4 for a closed row, and `T_PRE`+4 for a row change. The expected case is taken from the last row the bench accessed and from whether its memory model saw a refresh since then. Refresh spacing is measured between the row-strobe falls of two refreshes that happen back to back while the bus is idle. The measured gap must equal the interval exactly. All outputs are sampled on the falling clock edge, half a period away from the edge that updates them.

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl #(
  parameter int ROW_W         = 6,
  parameter int COL_W         = 6,
  parameter int DATA_W        = 8,
  parameter int CLK_NS        = 10,
  parameter int RETENTION_NS  = 2_000_000,
  parameter int REFRESH_COUNT = 128,
  parameter int T_PRE         = 2
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           req_valid,
  output logic                                           req_ready,
  input  logic                                           req_we,
  input  logic [ROW_W+COL_W-1:0]                         req_addr,
  input  logic [DATA_W-1:0]                              req_wdata,
  output logic                                           rsp_valid,
  output logic [DATA_W-1:0]                              rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0]   mem_addr,
  output logic                                           mem_ras_n,
  output logic                                           mem_cas_n,
  output logic                                           mem_we_n,
  output logic [DATA_W-1:0]                              mem_dq_out,
  output logic                                           mem_dq_oe,
  input  logic [DATA_W-1:0]                              mem_dq_in
);

  localparam int MUX_W        = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int REF_INTERVAL = RETENTION_NS / (CLK_NS * REFRESH_COUNT);
  localparam int RC_W         = $clog2(REF_INTERVAL) + 1;
  localparam int PC_W         = $clog2(T_PRE) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_RAS, S_COL, S_CAS, S_DONE, S_REF
  } state_t;

  state_t            st;
  logic              open_vld;
  logic [ROW_W-1:0]  open_row;
  logic              job;
  logic              j_we;
  logic [ROW_W-1:0]  j_row;
  logic [COL_W-1:0]  j_col;
  logic [DATA_W-1:0] j_wdata;
  logic [PC_W-1:0]   pre_cnt;
  logic [RC_W-1:0]   ref_tmr;
  logic              ref_pend;
  logic [ROW_W-1:0]  ref_row;
  logic [DATA_W-1:0] rdata;

  wire [ROW_W-1:0] in_row  = req_addr[ROW_W+COL_W-1:COL_W];
  wire             row_hit = open_vld && (in_row == open_row);
  wire             tmr_end = (ref_tmr == RC_W'(REF_INTERVAL - 1));
  wire             pre_end = (pre_cnt == PC_W'(T_PRE - 1));
  wire             col_ph  = (st == S_COL) || (st == S_CAS);

  assign req_ready = (st == S_IDLE) && !ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_tmr  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_tmr  <= tmr_end ? '0 : ref_tmr + 1'b1;
      ref_pend <= tmr_end || (ref_pend && (st != S_REF));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      open_vld <= 1'b0;
      open_row <= '0;
      job      <= 1'b0;
      j_we     <= 1'b0;
      j_row    <= '0;
      j_col    <= '0;
      j_wdata  <= '0;
      pre_cnt  <= '0;
      ref_row  <= '0;
      rdata    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            pre_cnt <= '0;
            if (open_vld) begin
              open_vld <= 1'b0;
              st       <= S_PRE;
            end else begin
              st <= S_REF;
            end
          end else if (req_valid) begin
            job     <= 1'b1;
            j_we    <= req_we;
            j_row   <= in_row;
            j_col   <= req_addr[COL_W-1:0];
            j_wdata <= req_wdata;
            pre_cnt <= '0;
            if (row_hit) begin
              st <= S_COL;
            end else if (open_vld) begin
              open_vld <= 1'b0;
              st       <= S_PRE;
            end else begin
              st <= S_RAS;
            end
          end
        end
        S_PRE: begin
          if (pre_end) begin
            if (job)           st <= S_RAS;
            else if (ref_pend) st <= S_REF;
            else               st <= S_IDLE;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        S_RAS: begin
          open_vld <= 1'b1;
          open_row <= j_row;
          st       <= S_COL;
        end
        S_COL: st <= S_CAS;
        S_CAS: begin
          rdata <= mem_dq_in;
          st    <= S_DONE;
        end
        S_DONE: begin
          job <= 1'b0;
          st  <= S_IDLE;
        end
        S_REF: begin
          ref_row <= ref_row + 1'b1;
          pre_cnt <= '0;
          st      <= S_PRE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_ras_n = !((st == S_RAS) || col_ph || (st == S_DONE) ||
                       (st == S_REF) || ((st == S_IDLE) && open_vld));
  assign mem_cas_n = (st != S_CAS);
  assign mem_addr  = (st == S_RAS) ? MUX_W'(j_row)   :
                     (st == S_REF) ? MUX_W'(ref_row) :
                     ((st == S_IDLE) && open_vld) ? MUX_W'(open_row) :
                     MUX_W'(j_col);
  assign mem_we_n   = !(col_ph && j_we);
  assign mem_dq_oe  = col_ph && j_we;
  assign mem_dq_out = j_wdata;
  assign rsp_valid  = (st == S_DONE);
  assign rsp_rdata  = rdata;

endmodule

// File: rtl/pagemode_dram_ctrl_chk.sv
module pagemode_dram_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int MUX_W  = 6,
  parameter int T_PRE  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [MUX_W-1:0]  mem_addr,
  input logic              req_ready,
  input logic              rsp_valid
);

  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt <= 8'hFF;
    else if (!mem_ras_n)                hi_cnt <= 8'd0;
    else if (hi_cnt != 8'hFF)           hi_cnt <= hi_cnt + 8'd1;
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> !mem_ras_n);  // R1

  AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> ($stable(mem_we_n) && $stable(mem_dq_oe) &&
                          $stable(mem_dq_out) && $stable(mem_addr)));  // R5

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cas_n && $past(!mem_cas_n)) |-> ($stable(mem_we_n) && $stable(mem_dq_out)));  // R5

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> (hi_cnt >= 8'(T_PRE)));  // R4

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R2

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cas_n && !rsp_valid));  // R8

endmodule

bind pagemode_dram_ctrl pagemode_dram_ctrl_chk #(
  .DATA_W(DATA_W), .MUX_W(MUX_W), .T_PRE(T_PRE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
  .mem_addr(mem_addr), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/test_pagemode_dram_ctrl.sv
module test_pagemode_dram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RET_NS     = 200_000;
  localparam int REF_N      = 128;
  localparam int TPRE       = 2;
  localparam int INTERVAL   = RET_NS / (CLK_PERIOD * REF_N);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [5:0]  mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagemode_dram_ctrl #(
    .CLK_NS(CLK_PERIOD), .RETENTION_NS(RET_NS), .REFRESH_COUNT(REF_N), .T_PRE(TPRE)
  ) i_pagemode_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // behavioural memory, observed on falling edges
  logic [7:0] mem [0:4095];
  logic [5:0] m_row = '0;
  logic       prev_ras = 1'b1, prev_cas = 1'b1, ras_only = 1'b0;
  int         cyc = 0, ras_falls = 0, ref_count = 0, ras_stamp = 0, ref_stamp = 0;
  logic [5:0] ref_last_row = '0;

  assign mem_dq_in = mem[{m_row, mem_addr}];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_ras && !mem_ras_n) begin
      m_row = mem_addr; ras_falls = ras_falls + 1; ras_only = 1'b1; ras_stamp = cyc;
    end
    if (prev_cas && !mem_cas_n) begin
      ras_only = 1'b0;
      if (!mem_we_n) mem[{m_row, mem_addr}] = mem_dq_out;
    end
    if (!prev_ras && mem_ras_n && ras_only) begin
      ref_count = ref_count + 1; ref_last_row = m_row; ref_stamp = ras_stamp; ras_only = 1'b0;
    end
    prev_ras = mem_ras_n;
    prev_cas = mem_cas_n;
  end

  int n_chk = 0, n_bad = 0;
  bit have_open = 1'b0;
  logic [5:0] open_row_exp = '0;
  int ref_snap = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'hC} ^ 8'h3C;
  endfunction

  task automatic access(input bit we, input logic [11:0] addr, input logic [7:0] wd,
                        input bit chk_rd, input logic [7:0] exp_rd);
    int lat, exp_lat, falls0;
    bit open_now, hit;
    string tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    open_now = have_open && (ref_count == ref_snap);
    hit      = open_now && (open_row_exp == addr[11:6]);
    exp_lat  = hit ? 3 : (open_now ? TPRE + 4 : 4);
    tag      = hit ? "R2" : (open_now ? "R4" : ((have_open) ? "R8" : "R3"));
    falls0   = ras_falls;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 40);
    check(lat == exp_lat, tag, "response latency", lat, exp_lat);
    check((ras_falls - falls0) == (hit ? 0 : 1), tag, "row strobe falls", ras_falls - falls0, hit ? 0 : 1);
    if (chk_rd) check(rsp_rdata == exp_rd, "R5", "read data", rsp_rdata, exp_rd);
    @(negedge clk);
    check(!rsp_valid, "R2", "response pulse width", rsp_valid, 0);
    have_open = 1'b1; open_row_exp = addr[11:6]; ref_snap = ref_count;
  endtask

  task automatic t_reset();
    check(mem_ras_n && mem_cas_n && mem_we_n, "R9", "strobes high in reset", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    check(!mem_dq_oe && !rsp_valid, "R9", "oe/rsp low in reset", {mem_dq_oe, rsp_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R9", "ready after reset", req_ready, 1);
    check(mem_ras_n && mem_cas_n, "R9", "strobes after reset", {mem_ras_n, mem_cas_n}, 3);
  endtask

  task automatic t_map_and_hit();
    logic [11:0] a = 12'h2C5;
    access(1'b1, a, 8'hA5, 1'b0, 8'h00);           // R3 closed row
    check(mem[a] == 8'hA5, "R1", "row/col placement in memory", mem[a], 8'hA5);
    access(1'b0, a, 8'h00, 1'b1, 8'hA5);           // R2 hit
    access(1'b1, 12'h2C6, 8'h5A, 1'b0, 8'h00);     // R2 hit write
    check(mem[12'h2C6] == 8'h5A, "R5", "hit write stored", mem[12'h2C6], 8'h5A);
  endtask

  task automatic t_row_change();
    access(1'b1, 12'h7C1, 8'h33, 1'b0, 8'h00);     // R4 miss
    access(1'b0, 12'h2C5, 8'h00, 1'b1, 8'hA5);     // R4 miss back
  endtask

  task automatic t_pattern();
    logic [11:0] list [6] = '{12'h000, 12'hFFF, 12'h03F, 12'hFC0, 12'h555, 12'hAAA};
    foreach (list[i]) access(1'b1, list[i], pat(list[i]), 1'b0, 8'h00);
    foreach (list[i]) access(1'b0, list[i], 8'h00, 1'b1, pat(list[i]));
    for (int c = 0; c < 4; c++) access(1'b1, {6'd9, 6'(c)}, pat({6'd9, 6'(c)}), 1'b0, 8'h00);
  endtask

  task automatic t_hits_through_refresh();
    int r0 = ref_count;
    for (int i = 0; i < 200; i++)
      access(1'b0, {6'd9, 6'(i % 4)}, 8'h00, 1'b1, pat({6'd9, 6'(i % 4)}));
    check((ref_count - r0) >= 2, "R8", "refreshes not starved by hits", ref_count - r0, 2);
  endtask

  task automatic t_refresh_spacing();
    int c0, s1;
    c0 = ref_count;
    while (ref_count < c0 + 2) @(negedge clk);
    s1 = ref_stamp;
    while (ref_count < c0 + 3) @(negedge clk);
    check((ref_stamp - s1) == INTERVAL, "R6", "refresh spacing", ref_stamp - s1, INTERVAL);
  endtask

  task automatic t_refresh_rows();
    int c;
    logic [5:0] prev;
    c = ref_count; prev = ref_last_row;
    for (int k = 0; k < 70; k++) begin
      while (ref_count == c) @(negedge clk);
      c = ref_count;
      check(ref_last_row == prev + 6'd1, "R7", "refresh row order", ref_last_row, 6'(prev + 6'd1));
      prev = ref_last_row;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    #(CLK_PERIOD * 3);
    t_reset();
    t_map_and_hit();
    t_row_change();
    t_pattern();
    t_hits_through_refresh();
    t_refresh_spacing();
    t_refresh_rows();
    access(1'b0, 12'h555, 8'h00, 1'b1, pat(12'h555));  // R8 closed after refresh
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule